// File: doc/BRIEF.md
# Framed Command Packet Receiver with CRC-16 Check

This block sits behind a UART receiver and turns its byte stream into checked command packets. A packet opens with a start byte and closes with an end byte. A prefix byte escapes any byte that would otherwise be read as a control value. The block strips the escapes and stores the payload in a buffer through a simple write port. It keeps a running CRC-16 over the payload. When the end byte arrives, it compares that CRC with the two-byte trailer.

At the end of each frame the block raises a one-cycle done pulse. A verdict flag goes with the pulse: accepted, protocol error, or neither when the CRC does not match. A mismatched frame is dropped without comment. After an accepted packet the receiver ignores the line until the consumer acknowledges it, so only one packet is outstanding at a time.

Top module: `pkt_rx_unframer`

## Requirements
- R1: Before a start byte (0x0F) is seen, every incoming byte is ignored, including 0x04 and 0x05. No buffer write and no done pulse result.
- R2: Outside an escape, 0x0F opens a packet and 0x04 closes it. A 0x0F received inside a packet restarts it with an empty payload, so repeated start bytes are absorbed. `pkt_done` pulses for one cycle, in the cycle after the closing byte is accepted.
- R3: The byte after an escape byte (0x05) is always taken as data, even when it equals 0x0F, 0x04 or 0x05.
- R4: Unescaped payload bytes are written to the buffer in arrival order at addresses 0, 1, 2 and so on. The two trailer bytes are never written. `pkt_len` gives the number of payload bytes stored.
- R5: The CRC uses polynomial 0x1021 with initial value 0x0000. It shifts MSB first, has no final XOR, and covers only the unescaped payload. The trailer is the low byte then the high byte. On a match `pkt_ok` is 1 during the done pulse.
- R6: On a CRC mismatch the done pulse carries `pkt_ok`=0 and `pkt_err`=0. The receiver goes straight back to waiting for a start byte, with no acknowledge.
- R7: After an accepted packet, all bytes are ignored (no writes, no done pulse) until `ack` is high for a cycle. After that a new packet is accepted.
- R8: When a packet has more than DEPTH payload bytes, only the first DEPTH are written. The done pulse then carries `pkt_err`=1 and `pkt_ok`=0.
- R9: A frame with fewer than three unescaped bytes between start and end gives a done pulse with `pkt_err`=1 and `pkt_ok`=0.
- R10: A packet whose only payload is one 0x00 byte, with trailer 0x00 0x00, is accepted with `pkt_len`=1.
- R11: After reset, `buf_we`, `pkt_done`, `pkt_ok`, `pkt_err` and `pkt_len` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| rx_valid | input | 1 | A received byte is present this cycle |
| rx_byte | input | 8 | Received byte |
| ack | input | 1 | Consumer has taken the accepted packet |
| buf_we | output | 1 | Buffer write strobe |
| buf_addr | output | $clog2(DEPTH) | Buffer write address |
| buf_data | output | 8 | Buffer write data |
| pkt_len | output | $clog2(DEPTH+1) | Payload byte count of the current or last packet |
| pkt_done | output | 1 | End-of-frame pulse |
| pkt_ok | output | 1 | Packet accepted; valid with pkt_done |
| pkt_err | output | 1 | Protocol error (overflow or too short); valid with pkt_done |

## Verification
A fault in the trailer holder or the escape state changes which bytes reach the buffer. That shows up as a wrong write count or wrong data within one byte time. It also shows up as a flipped verdict at the very next end byte. A bad CRC register or length counter shows up only at the done pulse, as a wrong `pkt_ok` or `pkt_len`. Random packets with random corruption catch these within a few frames. A state machine that fails to hold after acceptance shows up as soon as an unacknowledged frame produces writes or a done pulse.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
  localparam logic [7:0] CH_SOT = 8'h0F;
  localparam logic [7:0] CH_EOT = 8'h04;
  localparam logic [7:0] CH_ESC = 8'h05;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  typedef enum logic [1:0] {PS_IDLE, PS_BODY, PS_ESC, PS_HOLD} pstate_t;

  // One byte of CRC-16, MSB first, no reflection.
  function automatic logic [15:0] crc_step(logic [15:0] c, logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ CRC_POLY) : {r[14:0], 1'b0};
    return r;
  endfunction
endpackage

// File: rtl/pkt_crc_acc.sv
module pkt_crc_acc
  import pkt_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  always_ff @(posedge clk) begin
    if (!rst_n)   crc <= 16'h0000;
    else if (clr) crc <= 16'h0000;
    else if (en)  crc <= crc_step(crc, din);
  end
endmodule

// File: rtl/pkt_tail_hold.sv
module pkt_tail_hold (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       push,
  input  logic [7:0] din,
  output logic [7:0] older,
  output logic [7:0] newer,
  output logic       full,
  output logic       spill
);
  logic [1:0] cnt;

  assign full  = (cnt == 2'd2);
  assign spill = push && full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= 2'd0;
      older <= 8'h00;
      newer <= 8'h00;
    end else if (clr) begin
      cnt <= 2'd0;
    end else if (push) begin
      newer <= din;
      older <= newer;
      if (!full) cnt <= cnt + 2'd1;
    end
  end
endmodule

// File: rtl/pkt_rx_unframer.sv
module pkt_rx_unframer
  import pkt_rx_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_valid,
  input  logic [7:0]    rx_byte,
  input  logic          ack,
  output logic          buf_we,
  output logic [AW-1:0] buf_addr,
  output logic [7:0]    buf_data,
  output logic [LW-1:0] pkt_len,
  output logic          pkt_done,
  output logic          pkt_ok,
  output logic          pkt_err
);
  pstate_t     st;
  logic        ovf;
  logic [15:0] crc;
  logic [7:0]  t_old, t_new;
  logic        t_full, spill;

  // Named events
  logic in_frame, ev_sot, ev_esc, ev_eot, ev_data, room, held;
  logic too_short, crc_match, good;

  assign in_frame  = (st == PS_BODY);
  assign ev_sot    = rx_valid && (st == PS_IDLE || in_frame) && rx_byte == CH_SOT;
  assign ev_esc    = rx_valid && in_frame && rx_byte == CH_ESC;
  assign ev_eot    = rx_valid && in_frame && rx_byte == CH_EOT;
  assign ev_data   = rx_valid && ((in_frame && !ev_sot && !ev_esc && !ev_eot)
                                  || st == PS_ESC);
  assign room      = (pkt_len < LW'(DEPTH));
  assign held      = (st == PS_HOLD);
  assign too_short = !t_full || pkt_len == '0;
  assign crc_match = (crc == {t_new, t_old});
  assign good      = !ovf && !too_short && crc_match;

  pkt_tail_hold u_tail (
    .clk(clk), .rst_n(rst_n), .clr(ev_sot), .push(ev_data), .din(rx_byte),
    .older(t_old), .newer(t_new), .full(t_full), .spill(spill)
  );

  pkt_crc_acc u_crc (
    .clk(clk), .rst_n(rst_n), .clr(ev_sot), .en(spill), .din(t_old), .crc(crc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= PS_IDLE;
    end else begin
      unique case (st)
        PS_IDLE: if (ev_sot) st <= PS_BODY;
        PS_BODY: begin
          if (ev_esc)      st <= PS_ESC;
          else if (ev_eot) st <= good ? PS_HOLD : PS_IDLE;
        end
        PS_ESC:  if (rx_valid) st <= PS_BODY;
        PS_HOLD: if (ack) st <= PS_IDLE;
        default: st <= PS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pkt_len <= '0;
      ovf     <= 1'b0;
    end else if (ev_sot) begin
      pkt_len <= '0;
      ovf     <= 1'b0;
    end else if (spill) begin
      if (room) pkt_len <= pkt_len + LW'(1);
      else      ovf     <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_we   <= 1'b0;
      buf_addr <= '0;
      buf_data <= 8'h00;
      pkt_done <= 1'b0;
      pkt_ok   <= 1'b0;
      pkt_err  <= 1'b0;
    end else begin
      buf_we   <= spill && room;
      buf_addr <= pkt_len[AW-1:0];
      buf_data <= t_old;
      pkt_done <= ev_eot;
      pkt_ok   <= ev_eot && good;
      pkt_err  <= ev_eot && (ovf || too_short);
    end
  end
endmodule

// File: rtl/pkt_rx_chk.sv
module pkt_rx_chk #(
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rx_valid,
  input logic [7:0]    rx_byte,
  input logic          ack,
  input logic          buf_we,
  input logic [AW-1:0] buf_addr,
  input logic [LW-1:0] pkt_len,
  input logic          pkt_done,
  input logic          pkt_ok,
  input logic          pkt_err,
  input logic          held
);
  AST_DONE_ON_EOT: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |-> $past(rx_valid && rx_byte == 8'h04)); // R2
  AST_WR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> pkt_len == LW'(buf_addr) + LW'(1)); // R4
  AST_VERDICT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_ok || pkt_err) |-> (pkt_done && !(pkt_ok && pkt_err))); // R6
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(held) |-> (!buf_we && !pkt_done)); // R7
  AST_ACK_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (held && ack) |=> !held); // R7
  AST_LEN_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    buf_we |-> pkt_len <= LW'(DEPTH)); // R8
endmodule

bind pkt_rx_unframer pkt_rx_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack),
  .buf_we(buf_we), .buf_addr(buf_addr), .pkt_len(pkt_len), .pkt_done(pkt_done),
  .pkt_ok(pkt_ok), .pkt_err(pkt_err), .held(held)
);

// File: tb/sim_pkt_rx_unframer.sv
`timescale 1ns/1ps
module sim_pkt_rx_unframer;
  localparam int DEPTH = 64;
  localparam int AW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, rx_valid = 0, ack = 0;
  logic [7:0] rx_byte = 0;
  logic buf_we, pkt_done, pkt_ok, pkt_err;
  logic [AW-1:0] buf_addr;
  logic [7:0] buf_data;
  logic [LW-1:0] pkt_len;

  int total = 0, bad = 0;
  int wr_cnt = 0, done_cnt = 0;
  bit last_ok, last_err;
  logic [7:0] mem [0:DEPTH-1];
  logic [7:0] pl  [0:DEPTH+3];

  always #5 clk = ~clk;

  pkt_rx_unframer #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_byte(rx_byte), .ack(ack),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data), .pkt_len(pkt_len),
    .pkt_done(pkt_done), .pkt_ok(pkt_ok), .pkt_err(pkt_err)
  );

  always @(negedge clk) if (rst_n) begin
    if (buf_we) begin mem[buf_addr] = buf_data; wr_cnt++; end
    if (pkt_done) begin done_cnt++; last_ok = pkt_ok; last_err = pkt_err; end
  end

  task automatic chk(bit c, string tag, int act, int exp);
    total++;
    if (!c) begin bad++; $display("FAIL %s actual=%0d expected=%0d", tag, act, exp); end
  endtask

  // Bitwise serial CRC reference
  function automatic logic [15:0] ref_crc(int n);
    logic [15:0] c = 16'h0000;
    for (int k = 0; k < n; k++)
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = c[15] ^ pl[k][b];
        c = c << 1;
        if (fb) c = c ^ 16'h1021;
      end
    return c;
  endfunction

  task automatic sb(logic [7:0] b);
    rx_valid = 1; rx_byte = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic put(logic [7:0] b, bit force_esc);
    if (force_esc || b == 8'h0F || b == 8'h04 || b == 8'h05) sb(8'h05);
    sb(b);
  endtask

  task automatic do_ack();
    ack = 1; @(negedge clk); ack = 0;
  endtask

  task automatic run_frame(int n, bit corrupt, bit esc_all, bit eok, bit eerr,
                           int ewr, string tag);
    logic [15:0] c;
    int d0;
    @(negedge clk);
    wr_cnt = 0; d0 = done_cnt;
    c = ref_crc(n);
    if (corrupt) c = c ^ 16'h0100;
    sb(8'h0F);
    for (int k = 0; k < n; k++) put(pl[k], esc_all);
    put(c[7:0], esc_all);
    put(c[15:8], esc_all);
    sb(8'h04);
    @(negedge clk);
    chk(done_cnt == d0 + 1, {tag, " done count"}, done_cnt - d0, 1);
    chk(last_ok == eok, {tag, " pkt_ok"}, int'(last_ok), int'(eok));
    chk(last_err == eerr, {tag, " pkt_err"}, int'(last_err), int'(eerr));
    chk(wr_cnt == ewr, {tag, " write count"}, wr_cnt, ewr);
    if (eok) begin
      int mism = 0;
      chk(int'(pkt_len) == n, {tag, " pkt_len"}, int'(pkt_len), n);
      for (int k = 0; k < n; k++) if (mem[k] !== pl[k]) mism++;
      chk(mism == 0, {tag, " payload bytes"}, mism, 0);
    end
  endtask

  initial begin
    #2_000_000;
    bad++; total++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int d0;
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(buf_we == 0 && pkt_done == 0 && pkt_ok == 0 && pkt_err == 0 && pkt_len == 0,
        "R11 reset outputs", int'({buf_we, pkt_done, pkt_ok, pkt_err}), 0);
    rst_n = 1;
    @(negedge clk);

    // R1 garbage before start
    wr_cnt = 0; d0 = done_cnt;
    sb(8'h04); sb(8'h05); sb(8'h22); sb(8'h04); sb(8'h33);
    @(negedge clk);
    chk(done_cnt == d0 && wr_cnt == 0, "R1 idle ignore", done_cnt - d0 + wr_cnt, 0);

    // R5 basic good packet
    for (int k = 0; k < 5; k++) pl[k] = 8'h10 + 8'(k);
    run_frame(5, 0, 0, 1, 0, 5, "R5 good");
    do_ack();

    // R3 payload holding control values, and escape everything
    pl[0] = 8'h0F; pl[1] = 8'h04; pl[2] = 8'h05; pl[3] = 8'hA5;
    run_frame(4, 0, 0, 1, 0, 4, "R3 escaped controls");
    do_ack();
    run_frame(4, 0, 1, 1, 0, 4, "R3 escape all");
    do_ack();

    // R2 repeated start bytes absorbed, mid-packet restart
    sb(8'h0F); sb(8'h0F); sb(8'h0F);
    sb(8'h77); sb(8'h66); sb(8'h55); sb(8'h44);
    for (int k = 0; k < 3; k++) pl[k] = 8'hC0 + 8'(k);
    run_frame(3, 0, 0, 1, 0, 3, "R2 restart");
    do_ack();

    // R6 mismatch, then next packet without ack
    for (int k = 0; k < 6; k++) pl[k] = 8'($urandom);
    run_frame(6, 1, 0, 0, 0, 6, "R6 bad crc");
    run_frame(6, 0, 0, 1, 0, 6, "R6 next accepted");

    // R7 held until ack: a full frame is ignored
    wr_cnt = 0; d0 = done_cnt;
    sb(8'h0F); sb(8'h01); sb(8'h02); sb(8'h03); sb(8'h04);
    @(negedge clk);
    chk(done_cnt == d0 && wr_cnt == 0, "R7 held ignore", done_cnt - d0 + wr_cnt, 0);
    do_ack();
    run_frame(6, 0, 0, 1, 0, 6, "R7 after ack");
    do_ack();

    // R10 single zero command with zero trailer
    pl[0] = 8'h00;
    run_frame(1, 0, 0, 1, 0, 1, "R10 zero command");
    do_ack();

    // R9 too short
    d0 = done_cnt;
    sb(8'h0F); sb(8'h11); sb(8'h22); sb(8'h04);
    @(negedge clk);
    chk(done_cnt == d0 + 1 && last_err && !last_ok, "R9 short frame",
        int'({last_ok, last_err}), 1);

    // R8 overflow and exact fill
    for (int k = 0; k < DEPTH + 1; k++) pl[k] = 8'($urandom);
    run_frame(DEPTH + 1, 0, 0, 0, 1, DEPTH, "R8 overflow");
    run_frame(DEPTH, 0, 0, 1, 0, DEPTH, "R8 full buffer");
    do_ack();

    // Random packets, R4 ordering and R5/R6 verdicts
    for (int p = 0; p < 25; p++) begin
      int n;
      bit cor;
      n = 1 + int'($urandom % DEPTH);
      cor = ($urandom % 4) == 0;
      for (int k = 0; k < n; k++) pl[k] = 8'($urandom);
      run_frame(n, cor, ($urandom % 5) == 0, !cor, 0, n, "R4 random");
      if (!cor) do_ack();
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule